// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast oscillator clock down to a comparison pulse for a phase comparator. A prescaler divides the input by 10 or by 11. A main counter and a swallow counter sit behind it. The swallow counter keeps the prescaler at the longer ratio for the first A prescaler cycles of each output period. The main counter then closes the period after M+1 prescaler cycles. The total ratio is N = 10*(M+1) + A. Because the ratio changes inside each output period, every integer N in the usable range can be reached.

The modulus-select line is registered and brought out, so the sequencing can be observed. When the block is programmed over the serial path, one extra control bit bypasses the prescaler. The counters then run straight from the input clock with ratio M+1. Under direct (parallel) programming that bit does not exist and is ignored. Settings are sampled only at the end of an output period, so no period is ever cut short or stretched by a reprogramming.

A swallow value larger than the main value is illegal. Such a value is clamped to the main value and reported on an error flag.

Top module: `pswallow_div`

## Requirements
- R1: With the prescaler active, `fp` rises once every N = 10*(M+1)+A input clocks, where M = `m_val` and A = `a_val` (unsigned).
- R2: With the prescaler active, `msel` (1 = divide by 11, 0 = divide by 10) is high for exactly 11*A input clocks in each output period. Those clocks are the first ones of the period, starting with the clock in which `fp` is high.
- R3: When `serial_mode`=1 and `bypass_req`=1, the period of `fp` is M+1 input clocks and `msel` stays 0.
- R4: When `serial_mode`=0, `bypass_req` has no effect, and the period and `msel` follow R1 and R2.
- R5: If A > M while the prescaler is active, A is treated as equal to M, giving N = 10*(M+1)+M. `cfg_err` is 1 from the clock the setting is taken until the next setting is taken, and 0 for legal settings or in bypass.
- R6: Inputs are sampled only at the input-clock edge that ends an output period. The period under way completes with its old ratio, however the inputs change during it.
- R7: During reset `fp` is 0. After the first clock edge with `rst` low, the first `fp` is high after exactly N edges, using the settings present during reset.
- R8: `fp` is a registered pulse, one input clock wide, whenever N >= 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock from the oscillator |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1 = serial programming (bypass bit honoured), 0 = direct programming |
| bypass_req | input | 1 | Prescaler bypass request, used only when serial_mode=1 |
| m_val | input | 9 | Main counter setting M |
| a_val | input | 4 | Swallow counter setting A |
| fp | output | 1 | Divided comparison pulse to the phase comparator |
| msel | output | 1 | Prescaler modulus select, 1 = divide by 11 |
| cfg_err | output | 1 | Swallow setting exceeded main setting and was clamped |

## Verification
The settings reload and the terminal count of the main counter always fall in the same input clock. The edge that ends a period also starts the next one, with a fresh swallow count and a fresh modulus. The bench provokes this case by changing `m_val` and `a_val` immediately after a pulse, and again in the middle of a period. It judges the outcome by the exact lengths of two successive periods and by the number of `msel`-high clocks in each. A second coincidence is between the clamp and the reload: an illegal A must reach the swallow counter already clamped in the same clock. This is judged by the period length and by `cfg_err`.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  localparam int DEF_M_W  = 9;
  localparam int DEF_A_W  = 4;
  localparam int DEF_BASE = 10;

  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } mod_e;
endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
  import pswal_pkg::*;
#(
  parameter int PRE_BASE = DEF_BASE
) (
  input  logic clk,
  input  logic rst,
  input  mod_e mod_next,
  input  logic byp_next,
  output logic tick
);
  localparam int PC_W = $clog2(PRE_BASE + 1);
  localparam logic [PC_W-1:0] LIM_LONG  = PC_W'(PRE_BASE);
  localparam logic [PC_W-1:0] LIM_SHORT = PC_W'(PRE_BASE - 1);

  logic [PC_W-1:0] pc;

  assign tick = (pc == '0);

  always_ff @(posedge clk) begin
    if (rst || tick) begin
      if (byp_next)
        pc <= '0;
      else if (mod_next == MOD_PLUS1)
        pc <= LIM_LONG;
      else
        pc <= LIM_SHORT;
    end else begin
      pc <= pc - 1'b1;
    end
  end

  AST_PC_BOUND: assert property (@(posedge clk) disable iff (rst)
    pc <= LIM_LONG); // R1
endmodule

// File: rtl/pswal_ctrl.sv
module pswal_ctrl
  import pswal_pkg::*;
#(
  parameter int M_W = DEF_M_W,
  parameter int A_W = DEF_A_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           byp_in,
  output mod_e           mod_next,
  output logic           byp_next,
  output logic           msel,
  output logic           fp,
  output logic           cfg_err
);
  localparam int PAD_W = M_W - A_W;

  logic [M_W-1:0] m_act, mc, mc_d;
  logic [A_W-1:0] a_act, sc, sc_d, a_fix;
  logic           byp_act, a_over, term, load;

  always_comb begin
    a_over = ({{PAD_W{1'b0}}, a_in} > m_in);
    a_fix  = a_over ? m_in[A_W-1:0] : a_in;
    term   = tick && (mc == '0);
    load   = rst || term;
    byp_next = load ? byp_in : byp_act;
    if (load) begin
      mc_d = m_in;
      sc_d = byp_in ? '0 : a_fix;
    end else if (tick) begin
      mc_d = mc - 1'b1;
      sc_d = (sc != '0) ? sc - 1'b1 : '0;
    end else begin
      mc_d = mc;
      sc_d = sc;
    end
    mod_next = ((sc_d != '0) && !byp_next) ? MOD_PLUS1 : MOD_BASE;
  end

  always_ff @(posedge clk) begin
    mc      <= mc_d;
    sc      <= sc_d;
    byp_act <= byp_next;
    msel    <= (mod_next == MOD_PLUS1);
    fp      <= term && !rst;
    if (load) begin
      m_act   <= m_in;
      a_act   <= a_fix;
      cfg_err <= a_over && !byp_in;
    end
  end

  AST_A_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    {{PAD_W{1'b0}}, a_act} <= m_act); // R5

  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !term |=> ($stable(m_act) && $stable(a_act))); // R6

  AST_FP_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    (fp && !byp_act) |=> !fp); // R8

  AST_MSEL_SWALLOW: assert property (@(posedge clk) disable iff (rst)
    msel |-> (sc != '0 && !byp_act)); // R2
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswal_pkg::*;
#(
  parameter int M_W      = DEF_M_W,
  parameter int A_W      = DEF_A_W,
  parameter int PRE_BASE = DEF_BASE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           serial_mode,
  input  logic           bypass_req,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  output logic           fp,
  output logic           msel,
  output logic           cfg_err
);
  logic tick, byp_eff, byp_next;
  mod_e mod_next;

  // the bypass bit only exists on the serial programming path
  assign byp_eff = serial_mode && bypass_req;

  pswal_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .mod_next (mod_next),
    .byp_next (byp_next),
    .tick     (tick)
  );

  pswal_ctrl #(.M_W(M_W), .A_W(A_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .m_in     (m_val),
    .a_in     (a_val),
    .byp_in   (byp_eff),
    .mod_next (mod_next),
    .byp_next (byp_next),
    .msel     (msel),
    .fp       (fp),
    .cfg_err  (cfg_err)
  );

  AST_BYPASS_NO_MSEL: assert property (@(posedge clk) disable iff (rst)
    (fp && $past(byp_eff) && !$past(rst)) |-> !msel); // R3
endmodule

// File: tb/tb_pswallow_div.sv
module tb_pswallow_div;
  localparam int CLK_PERIOD = 10;
  localparam int LOOP_CAP   = 20000;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serial_mode = 1'b0;
  logic       bypass_req = 1'b0;
  logic [8:0] m_val = '0;
  logic [3:0] a_val = '0;
  logic       fp, msel, cfg_err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  pswallow_div dut (
    .clk(clk), .rst(rst), .serial_mode(serial_mode), .bypass_req(bypass_req),
    .m_val(m_val), .a_val(a_val), .fp(fp), .msel(msel), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, input int a, input bit ser, input bit byp);
    m_val = 9'(m);
    a_val = 4'(a);
    serial_mode = ser;
    bypass_req = byp;
  endtask

  task automatic sync_fp();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fp && n < LOOP_CAP);
  endtask

  // starts on a sample where fp is high; ends on the next such sample
  task automatic run_period(output int len, output int ms);
    len = 0;
    ms = msel ? 1 : 0;
    forever begin
      @(negedge clk);
      len++;
      if (fp || len >= LOOP_CAP) break;
      if (msel) ms++;
    end
  endtask

  task automatic t_reset();
    int n = 0;
    int len, ms;
    set_cfg(3, 2, 1'b0, 1'b0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 fp low in reset", fp, 0);
    rst = 1'b0;
    do begin
      @(negedge clk);
      n++;
    end while (!fp && n < LOOP_CAP);
    chk("R7 first pulse after reset", n, 42);
    run_period(len, ms);
    chk("R1 period M=3 A=2", len, 42);
    chk("R2 msel count M=3 A=2", ms, 22);
  endtask

  task automatic t_ratio(input int m, input int a, input bit ser, input bit byp,
                         input int exp_n, input int exp_ms, input string tag);
    int len, ms;
    set_cfg(m, a, ser, byp);
    sync_fp();
    run_period(len, ms);
    chk({tag, " period"}, len, exp_n);
    chk({tag, " msel clocks"}, ms, exp_ms);
    if (exp_n >= 2) begin
      @(negedge clk);
      chk("R8 fp one clock wide", fp, 0);
    end
  endtask

  task automatic t_clamp();
    int len, ms;
    set_cfg(2, 9, 1'b0, 1'b0);
    sync_fp();
    chk("R5 cfg_err set on A>M", cfg_err, 1);
    run_period(len, ms);
    chk("R5 clamped period", len, 32);
    chk("R5 clamped msel clocks", ms, 22);
    set_cfg(1, 9, 1'b1, 1'b1);
    sync_fp();
    chk("R5 cfg_err clear in bypass", cfg_err, 0);
    run_period(len, ms);
    chk("R5 R3 bypass period with large A", len, 2);
    set_cfg(5, 5, 1'b0, 1'b0);
    sync_fp();
    chk("R5 cfg_err clear for A=M", cfg_err, 0);
    run_period(len, ms);
    chk("R5 legal A=M period", len, 65);
  endtask

  task automatic t_reload();
    int len, ms;
    int n = 0;
    // change right after a pulse: the period just begun keeps the old ratio
    set_cfg(3, 1, 1'b0, 1'b0);
    sync_fp();
    sync_fp();
    set_cfg(5, 0, 1'b0, 1'b0);
    run_period(len, ms);
    chk("R6 old ratio after change at pulse", len, 41);
    chk("R6 old msel clocks", ms, 11);
    run_period(len, ms);
    chk("R6 new ratio next period", len, 60);
    chk("R6 new msel clocks", ms, 0);
    // change in the middle of a period
    set_cfg(3, 1, 1'b0, 1'b0);
    sync_fp();
    sync_fp();
    repeat (20) @(negedge clk);
    set_cfg(6, 4, 1'b0, 1'b0);
    do begin
      @(negedge clk);
      n++;
    end while (!fp && n < LOOP_CAP);
    chk("R6 mid-period change keeps remainder", n, 21);
    run_period(len, ms);
    chk("R6 period after mid change", len, 74);
    chk("R2 msel after mid change", ms, 44);
  endtask

  initial begin
    t_reset();
    t_ratio(0, 0, 1'b0, 1'b0, 10, 0, "R1 M=0 A=0");
    t_ratio(7, 7, 1'b0, 1'b0, 87, 77, "R1 R2 M=7 A=7");
    t_ratio(511, 15, 1'b0, 1'b0, 5135, 165, "R1 R2 max setting");
    t_ratio(4, 0, 1'b1, 1'b1, 5, 0, "R3 bypass M=4");
    t_ratio(1, 0, 1'b1, 1'b1, 2, 0, "R3 bypass M=1");
    t_ratio(4, 3, 1'b0, 1'b1, 53, 33, "R4 direct mode ignores bypass");
    t_ratio(4, 3, 1'b1, 1'b0, 53, 33, "R4 serial no bypass");
    t_clamp();
    t_reload();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule